// File: doc/BRIEF.md
# Phase-Rotated SIMD and Scalar Issue Scheduler

This block decides, every clock, which instructions leave the ready queues of a compute unit. Four vector SIMD units each run a four-clock cadence, and their cadences are staggered so that exactly one of them owns the start slot in any clock. A free-running phase counter names that owner. The block pops the owner's queue when it holds an instruction. In the same clock it may also pop one instruction from the shared scalar queue, whose slot is tagged with the same phase.

Two limits can hold the scalar instruction back. The first is fetch bandwidth: the bytes issued together may not exceed a per-clock budget. The second is the single scalar-register write port. A vector integer add always writes its per-lane carry mask through that port. If a scalar result would land in the same clock as a pending carry mask, the scalar instruction waits and a saturating stall counter records the held clock. The vector instruction is never delayed, because its slot comes back only once every four clocks.

Top module: `isu_issue_sched`

## Requirements
- R1: While `rst` is high, and in the first clock after it falls, every registered output is 0, `hazard_stalls` is 0, and no queue is popped. The phase counter reads 0 in the first clock after reset.
- R2: In the k-th clock after reset (counting from 0), only SIMD k mod 4 may be popped, and only when its `vq_valid` bit is set. `vq_pop` is a combinational one-hot-or-zero vector.
- R3: One clock after a vector pop, `v_iss_valid` is 1. In that clock `v_iss_simd` holds the popped SIMD index and `v_iss_instr` holds its instruction word. `v_iss_valid` is 0 after any clock with no vector pop.
- R4: A valid scalar instruction with no budget or port conflict is popped in the same clock. One clock later `s_iss_valid` is 1, `s_iss_instr` holds its word, and `s_iss_slot` holds the phase of the popping clock.
- R5: An instruction costs 8 bytes when its wide bit is 1 and 4 bytes otherwise. The scalar instruction is held in any clock where the vector cost plus the scalar cost exceeds 12 bytes. The vector cost is 0 when no vector is popped.
- R6: A vector pop whose `vq_iadd` bit is set gives `sreg_we`=1 and `sreg_from_vec`=1 exactly 5 clocks after the popping clock. `v_iss_iadd` is 1 one clock after the pop.
- R7: A scalar pop with `sc_wr_sreg`=1 gives `sreg_we`=1 and `sreg_from_vec`=0 exactly 4 clocks after the popping clock.
- R8: A scalar instruction with `sc_wr_sreg`=1 is held when its write would land in the same clock as a pending carry mask, which with the default latencies means a vector integer add was popped one clock earlier. Each held clock increments `hazard_stalls` by one.
- R9: The scalar-register write port never carries a carry mask and a scalar result in the same clock.
- R10: A scalar instruction with `sc_wr_sreg`=0 is never held by a pending carry mask and never increments `hazard_stalls`.
- R11: `hazard_stalls` saturates at its all-ones value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vq_valid | input | NSIMD | Per-SIMD ready queue holds an instruction |
| vq_iadd | input | NSIMD | Head instruction is a vector integer add (writes a carry mask) |
| vq_wide | input | NSIMD | Head instruction is 8 bytes (else 4) |
| vq_instr | input | NSIMD*IW | Head instruction words, SIMD n at bits n*IW upward |
| vq_pop | output | NSIMD | Pop strobe to the per-SIMD queues |
| sc_valid | input | 1 | Scalar queue holds an instruction |
| sc_wide | input | 1 | Scalar instruction is 8 bytes (else 4) |
| sc_wr_sreg | input | 1 | Scalar instruction writes the scalar register file |
| sc_instr | input | IW | Scalar instruction word |
| sc_pop | output | 1 | Pop strobe to the scalar queue |
| v_iss_valid | output | 1 | Registered vector issue strobe |
| v_iss_simd | output | PH_W | Target SIMD of the vector issue |
| v_iss_iadd | output | 1 | Issued vector instruction is an integer add |
| v_iss_instr | output | IW | Issued vector instruction word |
| s_iss_valid | output | 1 | Registered scalar issue strobe |
| s_iss_slot | output | PH_W | Phase slot the scalar instruction took |
| s_iss_instr | output | IW | Issued scalar instruction word |
| sreg_we | output | 1 | Scalar-register write port active this clock |
| sreg_from_vec | output | 1 | The active write is a vector carry mask |
| hazard_stalls | output | CNT_W | Saturating count of scalar clocks held by the write port |

## Verification
The bench builds the block with four SIMDs, 16-bit instruction words, a vector carry latency of 5 and a scalar latency of 4. Under these values the one-clock-apart collision between a carry mask and a scalar write can occur. The counter width is set to 4 bits, so a short run of back-to-back integer adds drives `hazard_stalls` into saturation. Random queue occupancy, mixed widths and mixed register-writing scalars exercise every phase slot under both the byte budget and the port hazard.

// File: rtl/isu_pkg.sv
package isu_pkg;

  // Byte cost of one instruction given its width flag.
  function automatic int instr_bytes(input logic wide, input int narrow_b, input int wide_b);
    return wide ? wide_b : narrow_b;
  endfunction

  // Width of a phase index for n units (at least one bit).
  function automatic int phase_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/isu_phase_ring.sv
module isu_phase_ring #(
  parameter int NSIMD = 4,
  localparam int PH_W = isu_pkg::phase_bits(NSIMD)
) (
  input  logic            clk,
  input  logic            rst,
  output logic [PH_W-1:0] phase
);
  localparam logic [PH_W-1:0] LAST = PH_W'(NSIMD - 1);

  always_ff @(posedge clk) begin
    if (rst)                phase <= '0;
    else if (phase == LAST) phase <= '0;
    else                    phase <= phase + 1'b1;
  end

  // R2: the slot owner advances by one each clock and wraps after the last SIMD
  assert_phase_step_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (phase == (($past(phase) == LAST) ? '0 : $past(phase) + 1'b1)));
endmodule

// File: rtl/isu_vec_pick.sv
module isu_vec_pick #(
  parameter int NSIMD = 4,
  parameter int IW    = 32,
  localparam int PH_W = isu_pkg::phase_bits(NSIMD)
) (
  input  logic              en,
  input  logic [PH_W-1:0]   phase,
  input  logic [NSIMD-1:0]  vq_valid,
  input  logic [NSIMD-1:0]  vq_iadd,
  input  logic [NSIMD-1:0]  vq_wide,
  input  logic [NSIMD*IW-1:0] vq_instr,
  output logic [NSIMD-1:0]  pop,
  output logic              pick_valid,
  output logic              pick_iadd,
  output logic              pick_wide,
  output logic [IW-1:0]     pick_instr
);
  logic [NSIMD-1:0] slot_own;

  for (genvar g = 0; g < NSIMD; g++) begin : g_lane
    assign slot_own[g] = (phase == PH_W'(g));
    assign pop[g]      = en && slot_own[g] && vq_valid[g];
  end

  always_comb begin
    pick_iadd  = 1'b0;
    pick_wide  = 1'b0;
    pick_instr = '0;
    for (int i = 0; i < NSIMD; i++) begin
      if (pop[i]) begin
        pick_iadd  = vq_iadd[i];
        pick_wide  = vq_wide[i];
        pick_instr = vq_instr[i*IW +: IW];
      end
    end
  end

  assign pick_valid = |pop;

  // R2: a pop never reaches an empty queue, and at most one lane is popped
  always_comb begin
    assert_pop_valid_R2: assert ((pop & ~vq_valid) == '0);
    assert_pop_single_R2: assert ($onehot0(pop));
  end
endmodule

// File: rtl/isu_sreg_port.sv
module isu_sreg_port #(
  parameter int VLAT = 5,
  parameter int SLAT = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic carry_issue,
  input  logic sca_issue,
  output logic hazard,
  output logic sreg_we,
  output logic sreg_from_vec
);
  // Bit i of each line marks a write landing i clocks from now.
  logic [VLAT-1:0] carry_line;
  logic [SLAT-1:0] sca_line;

  always_ff @(posedge clk) begin
    if (rst) begin
      carry_line <= '0;
      sca_line   <= '0;
    end else begin
      for (int i = 0; i < VLAT - 1; i++) carry_line[i] <= carry_line[i+1];
      carry_line[VLAT-1] <= carry_issue;
      for (int i = 0; i < SLAT - 1; i++) sca_line[i] <= sca_line[i+1];
      sca_line[SLAT-1] <= sca_issue;
    end
  end

  // A scalar write landing SLAT clocks out meets a carry already in flight,
  // or a carry issued in this same clock when both latencies match.
  if (SLAT == VLAT) begin : g_same_lat
    assign hazard = carry_issue;
  end else begin : g_diff_lat
    assign hazard = carry_line[SLAT];
  end

  assign sreg_we       = carry_line[0] | sca_line[0];
  assign sreg_from_vec = carry_line[0];

  // R9: one writer per clock on the scalar-register port
  assert_one_writer_R9: assert property (@(posedge clk) disable iff (rst)
    !(carry_line[0] && sca_line[0]));
  // R8: the issue logic never lets a scalar writer through into a busy slot
  assert_hazard_obeyed_R8: assert property (@(posedge clk) disable iff (rst)
    sca_issue |-> !hazard);
endmodule

// File: rtl/isu_issue_sched.sv
module isu_issue_sched #(
  parameter int NSIMD    = 4,
  parameter int IW       = 32,
  parameter int VLAT     = 5,
  parameter int SLAT     = 4,
  parameter int CNT_W    = 16,
  parameter int NARROW_B = 4,
  parameter int WIDE_B   = 8,
  parameter int BUDGET_B = 12,
  localparam int PH_W    = isu_pkg::phase_bits(NSIMD)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NSIMD-1:0]    vq_valid,
  input  logic [NSIMD-1:0]    vq_iadd,
  input  logic [NSIMD-1:0]    vq_wide,
  input  logic [NSIMD*IW-1:0] vq_instr,
  output logic [NSIMD-1:0]    vq_pop,
  input  logic                sc_valid,
  input  logic                sc_wide,
  input  logic                sc_wr_sreg,
  input  logic [IW-1:0]       sc_instr,
  output logic                sc_pop,
  output logic                v_iss_valid,
  output logic [PH_W-1:0]     v_iss_simd,
  output logic                v_iss_iadd,
  output logic [IW-1:0]       v_iss_instr,
  output logic                s_iss_valid,
  output logic [PH_W-1:0]     s_iss_slot,
  output logic [IW-1:0]       s_iss_instr,
  output logic                sreg_we,
  output logic                sreg_from_vec,
  output logic [CNT_W-1:0]    hazard_stalls
);
  import isu_pkg::*;

  logic [PH_W-1:0] phase;
  logic            v_go, v_iadd, v_wide;
  logic [IW-1:0]   v_instr;
  logic            port_hazard;
  logic            fits, blocked, s_go, stall_inc;
  int              v_cost, s_cost;

  isu_phase_ring #(.NSIMD(NSIMD)) u_ring (
    .clk(clk), .rst(rst), .phase(phase)
  );

  isu_vec_pick #(.NSIMD(NSIMD), .IW(IW)) u_pick (
    .en(!rst), .phase(phase),
    .vq_valid(vq_valid), .vq_iadd(vq_iadd), .vq_wide(vq_wide), .vq_instr(vq_instr),
    .pop(vq_pop), .pick_valid(v_go), .pick_iadd(v_iadd), .pick_wide(v_wide),
    .pick_instr(v_instr)
  );

  isu_sreg_port #(.VLAT(VLAT), .SLAT(SLAT)) u_port (
    .clk(clk), .rst(rst),
    .carry_issue(v_go && v_iadd),
    .sca_issue(s_go && sc_wr_sreg),
    .hazard(port_hazard),
    .sreg_we(sreg_we), .sreg_from_vec(sreg_from_vec)
  );

  // Scalar admission: byte budget shared with the vector slot, then the port.
  always_comb begin
    v_cost    = v_go ? instr_bytes(v_wide, NARROW_B, WIDE_B) : 0;
    s_cost    = instr_bytes(sc_wide, NARROW_B, WIDE_B);
    fits      = (v_cost + s_cost) <= BUDGET_B;
    blocked   = sc_wr_sreg && port_hazard;
    s_go      = !rst && sc_valid && fits && !blocked;
    stall_inc = !rst && sc_valid && blocked;
  end

  assign sc_pop = s_go;

  always_ff @(posedge clk) begin
    if (rst) begin
      v_iss_valid   <= 1'b0;
      v_iss_simd    <= '0;
      v_iss_iadd    <= 1'b0;
      v_iss_instr   <= '0;
      s_iss_valid   <= 1'b0;
      s_iss_slot    <= '0;
      s_iss_instr   <= '0;
      hazard_stalls <= '0;
    end else begin
      v_iss_valid <= v_go;
      v_iss_iadd  <= v_go && v_iadd;
      if (v_go) begin
        v_iss_simd  <= phase;
        v_iss_instr <= v_instr;
      end
      s_iss_valid <= s_go;
      if (s_go) begin
        s_iss_slot  <= phase;
        s_iss_instr <= sc_instr;
      end
      if (stall_inc && hazard_stalls != '1)
        hazard_stalls <= hazard_stalls + 1'b1;
    end
  end

  // R3: a vector pop shows up as an issue one clock later
  assert_vec_issue_R3: assert property (@(posedge clk) disable iff (rst)
    (|vq_pop) |=> v_iss_valid);
  // R4: a scalar pop shows up as an issue one clock later
  assert_sca_issue_R4: assert property (@(posedge clk) disable iff (rst)
    sc_pop |=> s_iss_valid);
  // R5: two wide instructions never leave in the same clock with the default budget
  assert_budget_R5: assert property (@(posedge clk) disable iff (rst)
    (sc_pop && (|vq_pop)) |-> ((|(vq_pop & vq_wide)) ? 8 : 4) + (sc_wide ? 8 : 4) <= BUDGET_B);
  // R10: a scalar that writes no scalar register is not stalled by the port
  assert_no_stall_nonwriter_R10: assert property (@(posedge clk) disable iff (rst)
    (sc_valid && !sc_wr_sreg) |=> $stable(hazard_stalls));
  // R11: once saturated, the stall count stays at all-ones
  assert_stall_sat_R11: assert property (@(posedge clk) disable iff (rst)
    (hazard_stalls == '1) |=> (hazard_stalls == '1));
endmodule

// File: tb/isu_issue_sched_bench.sv
module isu_issue_sched_bench;
  localparam int NS = 4, IW = 16, VL = 5, SL = 4, CW = 4, PW = 2;

  logic clk = 1'b0, rst = 1'b1;
  always #5 clk = ~clk;

  logic [NS-1:0]    vq_valid = '0, vq_iadd = '0, vq_wide = '0, vq_pop;
  logic [NS*IW-1:0] vq_instr = '0;
  logic             sc_valid = 1'b0, sc_wide = 1'b0, sc_wr_sreg = 1'b0, sc_pop;
  logic [IW-1:0]    sc_instr = '0;
  logic             v_iss_valid, v_iss_iadd, s_iss_valid, sreg_we, sreg_from_vec;
  logic [PW-1:0]    v_iss_simd, s_iss_slot;
  logic [IW-1:0]    v_iss_instr, s_iss_instr;
  logic [CW-1:0]    hazard_stalls;

  isu_issue_sched #(.NSIMD(NS), .IW(IW), .VLAT(VL), .SLAT(SL), .CNT_W(CW)) u_isu_issue_sched (
    .clk(clk), .rst(rst), .vq_valid(vq_valid), .vq_iadd(vq_iadd), .vq_wide(vq_wide),
    .vq_instr(vq_instr), .vq_pop(vq_pop), .sc_valid(sc_valid), .sc_wide(sc_wide),
    .sc_wr_sreg(sc_wr_sreg), .sc_instr(sc_instr), .sc_pop(sc_pop),
    .v_iss_valid(v_iss_valid), .v_iss_simd(v_iss_simd), .v_iss_iadd(v_iss_iadd),
    .v_iss_instr(v_iss_instr), .s_iss_valid(s_iss_valid), .s_iss_slot(s_iss_slot),
    .s_iss_instr(s_iss_instr), .sreg_we(sreg_we), .sreg_from_vec(sreg_from_vec),
    .hazard_stalls(hazard_stalls)
  );

  int n_tests = 0, n_fail = 0, cyc = 0;
  bit wb_vec[64], wb_sca[64];
  bit e_vv, e_viadd, e_sv;
  int e_vsimd, e_sslot, e_stall;
  logic [IW-1:0] e_vinstr, e_sinstr;

  task automatic chk(input string tag, input longint act, input longint exp, input string what);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s cycle %0d: actual %0h expected %0h", tag, what, cyc, act, exp);
    end
  endtask

  function automatic int cost(input bit w);
    return w ? 8 : 4;
  endfunction

  // One clock: check registered outputs, drive inputs, check pops, predict.
  task automatic step(input logic [NS-1:0] vv, input logic [NS-1:0] ia, input logic [NS-1:0] wd,
                      input bit sv, input bit sw, input bit swr);
    int ph, vb, slot;
    bit vgo, hz, sgo;
    chk("R3", v_iss_valid, e_vv, "v_iss_valid");
    if (e_vv) begin
      chk("R3", v_iss_simd, e_vsimd, "v_iss_simd");
      chk("R3", v_iss_instr, e_vinstr, "v_iss_instr");
    end
    chk("R6", v_iss_iadd, e_viadd, "v_iss_iadd");
    chk("R4", s_iss_valid, e_sv, "s_iss_valid");
    if (e_sv) begin
      chk("R4", s_iss_slot, e_sslot, "s_iss_slot");
      chk("R4", s_iss_instr, e_sinstr, "s_iss_instr");
    end
    slot = cyc % 64;
    chk(wb_vec[slot] ? "R6" : "R7", sreg_we, wb_vec[slot] | wb_sca[slot], "sreg_we");
    chk("R9", sreg_from_vec, wb_vec[slot], "sreg_from_vec");
    wb_vec[slot] = 0; wb_sca[slot] = 0;
    chk("R8", hazard_stalls, e_stall, "hazard_stalls");

    vq_valid = vv; vq_iadd = ia; vq_wide = wd;
    for (int i = 0; i < NS; i++) vq_instr[i*IW +: IW] = IW'($urandom);
    sc_valid = sv; sc_wide = sw; sc_wr_sreg = swr; sc_instr = IW'($urandom);
    #1;
    ph  = cyc % NS;
    vgo = vv[ph];
    chk("R2", vq_pop, vgo ? (1 << ph) : 0, "vq_pop");
    vb  = vgo ? cost(wd[ph]) : 0;
    hz  = swr && wb_vec[(cyc + SL) % 64];
    sgo = sv && (vb + cost(sw) <= 12) && !hz;
    chk(hz ? "R8" : (swr ? "R5" : "R10"), sc_pop, sgo, "sc_pop");

    e_vv = vgo; e_vsimd = ph; e_vinstr = vq_instr[ph*IW +: IW];
    e_viadd = vgo && ia[ph];
    e_sv = sgo; e_sslot = ph; e_sinstr = sc_instr;
    if (vgo && ia[ph]) wb_vec[(cyc + VL) % 64] = 1;
    if (sgo && swr)    wb_sca[(cyc + SL) % 64] = 1;
    if (sv && hz && e_stall < 15) e_stall++;   // R11 saturation at 4'hF
    @(posedge clk); @(negedge clk);
    cyc++;
  endtask

  initial begin
    #(200000 * 10);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 64; i++) begin wb_vec[i] = 0; wb_sca[i] = 0; end
    e_vv = 0; e_viadd = 0; e_sv = 0; e_vsimd = 0; e_sslot = 0; e_stall = 0;
    e_vinstr = '0; e_sinstr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: state while reset is held, with every queue offering work
    vq_valid = '1; sc_valid = 1'b1; #1;
    chk("R1", vq_pop, 0, "vq_pop in reset");
    chk("R1", sc_pop, 0, "sc_pop in reset");
    chk("R1", {v_iss_valid, s_iss_valid, sreg_we, v_iss_iadd}, 0, "issue outputs in reset");
    chk("R1", hazard_stalls, 0, "hazard_stalls in reset");
    @(negedge clk);
    rst = 1'b0;
    // R1/R2: the first clock belongs to SIMD 0, then the slot rotates
    repeat (8) step(4'hF, 4'h0, 4'h0, 1, 0, 0);
    // R6/R8: integer add, then a scalar writer one clock later is held once
    step(4'hF, 4'hF, 4'h0, 0, 0, 0);
    step(4'h0, 4'h0, 4'h0, 1, 0, 1);
    step(4'h0, 4'h0, 4'h0, 1, 0, 1);
    repeat (6) step(4'h0, 4'h0, 4'h0, 0, 0, 0);
    // R10: integer add, then a scalar that writes no scalar register
    step(4'hF, 4'hF, 4'h0, 0, 0, 0);
    step(4'h0, 4'h0, 4'h0, 1, 1, 0);
    // R5: wide vector with wide scalar is held; narrow scalar passes
    step(4'hF, 4'h0, 4'hF, 1, 1, 0);
    step(4'hF, 4'h0, 4'hF, 1, 0, 0);
    step(4'h0, 4'h0, 4'h0, 1, 1, 1);
    step(4'hF, 4'h0, 4'h0, 1, 1, 1);
    // R7: isolated scalar writes land four clocks later
    repeat (6) step(4'h0, 4'h0, 4'h0, 1, 0, 1);
    // Random mix over all slots
    for (int n = 0; n < 600; n++)
      step(NS'($urandom), NS'($urandom), NS'($urandom),
           bit'($urandom % 4 != 0), bit'($urandom), bit'($urandom));
    // R11: back-to-back integer adds keep the scalar writer held until saturation
    repeat (24) step(4'hF, 4'hF, 4'h0, 1, 0, 1);
    repeat (8) step(4'h0, 4'h0, 4'h0, 0, 0, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule